// File: doc/BRIEF.md
# Systolic Stack Sorter

This block sorts a burst of up to `DEPTH` unsigned keys in a vertical chain of `DEPTH/2` comparison cells. Each cell holds an ordered pair of slots, and each slot carries a valid bit. An empty slot compares as larger than any key. Keys enter and leave at the top cell only. While keys are loaded, every cell compares the arriving key with its pair, keeps the two smallest, and hands the largest to the cell below one cycle later. While keys are drained, every cell hands its smaller slot upward and refills from the cell below. The smallest stored key therefore always leaves the top first.

A single mode input chooses between loading and draining. A key is loaded in any cycle with mode low, `in_valid` high and the stack not full. A key is drained in any cycle with mode high, the stack not empty and no loaded key still moving down the chain. The caller loads a burst, raises the mode input, and collects one ascending key per `out_valid` until `empty` rises. Loading may resume after a partial drain, and the stack stays correctly ordered.

Top module: `ssort_stack`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `out_valid` is 0.
- R2: A key is stored only at a rising edge where `mode_pop`=0, `in_valid`=1 and `full`=0. In any other cycle, including all cycles with `mode_pop`=1, `in_data` has no effect on the keys drained later.
- R3: `full` is 1 exactly when `DEPTH` keys are stored, and it is visible from the cycle after the edge that stored the last key. Load attempts while full are dropped, and no key is ever lost off the bottom cell.
- R4: Keys are drained in non-decreasing unsigned order, each one the smallest key then stored.
- R5: A drain yields exactly as many `out_valid` pulses as there are stored keys, then `empty` is 1 and `out_valid` stays 0.
- R6: Duplicate keys are all kept and each is drained once.
- R7: `out_valid` and `out_data` are registered and appear in the cycle after the edge that drained the key. Draining waits while a loaded key is still moving down, so the first key appears no more than `DEPTH/2` cycles after `mode_pop` rises.
- R8: Loading after a partial drain is allowed, and the next drain returns the remaining and the new keys merged in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pop | input | 1 | 0 = load phase, 1 = drain phase |
| in_valid | input | 1 | Load request for `in_data` |
| in_data | input | KEY_W | Key to load (unsigned) |
| out_valid | output | 1 | A drained key is on `out_data` |
| out_data | output | KEY_W | Drained key |
| full | output | 1 | DEPTH keys stored |
| empty | output | 1 | No key stored |

## Verification
The flags change at the edge that stores or drains a key, and `out_valid` rises at the same edge that drains a key. The bench drives every input at a falling edge and samples one falling edge later, so each sample sees the result of exactly one rising edge. The drain start depends on how far the last loaded keys still have to descend. The bench therefore does not fix the cycle of the first key. It keeps `mode_pop` high, collects every `out_valid` cycle in a window longer than any possible wait, and counts the cycles to the first key against the `DEPTH/2` bound of R7. For partial drains, `mode_pop` is lowered at the falling edge where the k-th key is seen, so no further key is drained.

// File: rtl/ssort_pkg.sv
package ssort_pkg;

  parameter int unsigned KEY_W = 8;

  typedef struct packed {
    logic             vld;
    logic [KEY_W-1:0] key;
  } slot_t;

  localparam slot_t SLOT_EMPTY = '{vld: 1'b0, key: '0};

  // a <= b, with an empty slot ranked above every key
  function automatic logic slot_le(input slot_t a, input slot_t b);
    return (!b.vld) || (a.vld && (a.key <= b.key));
  endfunction

  function automatic slot_t slot_min(input slot_t a, input slot_t b);
    return slot_le(a, b) ? a : b;
  endfunction

  function automatic slot_t slot_max(input slot_t a, input slot_t b);
    return slot_le(a, b) ? b : a;
  endfunction

endpackage

// File: rtl/ssort_cell.sv
module ssort_cell
  import ssort_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pop_en,
  input  slot_t dn_in,
  input  slot_t up_in,
  output slot_t dn_out,
  output slot_t up_out
);

  slot_t lo_q, hi_q, dn_q;
  slot_t ins_lo, ins_mid, ins_hi;
  slot_t rem_lo, rem_hi;

  // three-way order of the held pair with the key arriving from above
  always_comb begin
    if (slot_le(dn_in, lo_q)) begin
      ins_lo  = dn_in;
      ins_mid = lo_q;
      ins_hi  = hi_q;
    end else if (slot_le(dn_in, hi_q)) begin
      ins_lo  = lo_q;
      ins_mid = dn_in;
      ins_hi  = hi_q;
    end else begin
      ins_lo  = lo_q;
      ins_mid = hi_q;
      ins_hi  = dn_in;
    end
  end

  // after handing lo upward, the pair is hi plus the minimum from below
  always_comb begin
    rem_lo = slot_min(hi_q, up_in);
    rem_hi = slot_max(hi_q, up_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= SLOT_EMPTY;
      hi_q <= SLOT_EMPTY;
      dn_q <= SLOT_EMPTY;
    end else if (pop_en) begin
      lo_q <= rem_lo;
      hi_q <= rem_hi;
      dn_q <= SLOT_EMPTY;
    end else if (dn_in.vld) begin
      lo_q <= ins_lo;
      hi_q <= ins_mid;
      dn_q <= ins_hi;
    end else begin
      dn_q <= SLOT_EMPTY;
    end
  end

  assign up_out = lo_q;
  assign dn_out = dn_q;

  // R4: the pair stays ordered, and an occupied hi implies an occupied lo
  assert_pair_ordered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_le(lo_q, hi_q));

  // R7: a drain never meets a key still descending into this cell
  assert_no_drain_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_en && dn_in.vld));

endmodule

// File: rtl/ssort_ctrl.sv
module ssort_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pop,
  input  logic in_valid,
  input  logic busy,
  output logic push_fire,
  output logic pop_fire,
  output logic full,
  output logic empty
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count_q;

  assign full      = (count_q == CNT_MAX);
  assign empty     = (count_q == '0);
  assign push_fire = !mode_pop && in_valid && !full;
  assign pop_fire  = mode_pop && !empty && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)         count_q <= '0;
    else if (push_fire) count_q <= count_q + 1'b1;
    else if (pop_fire)  count_q <= count_q - 1'b1;
  end

  // R3: the occupancy never exceeds the stack capacity
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_MAX);

  // R2: the occupancy only changes when a load or drain was accepted
  assert_count_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_fire && !pop_fire) |=> $stable(count_q));

endmodule

// File: rtl/ssort_stack.sv
module ssort_stack
  import ssort_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CELLS = (DEPTH + 1) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_pop,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_data,
  output logic             out_valid,
  output logic [KEY_W-1:0] out_data,
  output logic             full,
  output logic             empty
);

  slot_t chain_dn [0:CELLS];
  slot_t chain_up [0:CELLS];
  logic  push_fire, pop_fire, busy;
  logic  out_valid_q;
  logic [KEY_W-1:0] out_data_q;

  ssort_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_pop  (mode_pop),
    .in_valid  (in_valid),
    .busy      (busy),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .full      (full),
    .empty     (empty)
  );

  assign chain_dn[0]     = '{vld: push_fire, key: in_data};
  assign chain_up[CELLS] = SLOT_EMPTY;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    ssort_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .pop_en (pop_fire),
      .dn_in  (chain_dn[k]),
      .up_in  (chain_up[k+1]),
      .dn_out (chain_dn[k+1]),
      .up_out (chain_up[k])
    );
  end

  // a key is still descending if any inter-cell carry is occupied
  always_comb begin
    busy = 1'b0;
    for (int k = 1; k < CELLS; k++) busy = busy | chain_dn[k].vld;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= pop_fire;
      if (pop_fire) out_data_q <= chain_up[0].key;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  // R3: nothing ever falls out of the bottom cell
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_dn[CELLS].vld);

  // R4: back-to-back drained keys never decrease
  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && $past(out_valid_q)) |-> (out_data_q >= $past(out_data_q)));

  // R5: the occupancy flag and the top slot agree on emptiness
  assert_empty_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !busy) |-> !chain_up[0].vld);

  // R5: a drain only happens when a key sits at the top
  assert_drain_has_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> chain_up[0].vld);

endmodule

// File: tb/tb_ssort_stack.sv
module tb_ssort_stack;
  import ssort_pkg::*;

  localparam int unsigned DEPTH = 8;
  localparam int unsigned CELLS = DEPTH / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pop = 1'b0;
  logic in_valid = 1'b0;
  logic [KEY_W-1:0] in_data = '0;
  logic out_valid, full, empty;
  logic [KEY_W-1:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  int model [0:31];
  int model_n = 0;
  int first_lat;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  ssort_stack #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .mode_pop(mode_pop), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .full(full), .empty(empty)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: act=%0d exp<=150000", wd);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:16]);
  endfunction

  // bench model: the smallest held value, removed by linear search
  function automatic int model_take();
    int best = 0;
    int v;
    for (int i = 1; i < model_n; i++) if (model[i] < model[best]) best = i;
    v = model[best];
    model[best] = model[model_n-1];
    model_n--;
    return v;
  endfunction

  task automatic push(input int v);
    @(negedge clk);
    mode_pop = 1'b0; in_valid = 1'b1; in_data = KEY_W'(v);
    if (model_n < DEPTH) begin model[model_n] = v; model_n++; end
  endtask

  task automatic idle(input int v);
    @(negedge clk);
    in_valid = 1'b0; in_data = KEY_W'(v);
  endtask

  // drain up to k keys (k<0: all); checks order, count and the empty flag
  task automatic drain(input int k, input string req);
    int got = 0;
    int exp_n = model_n;
    first_lat = -1;
    @(negedge clk);
    mode_pop = 1'b1; in_valid = 1'b0;
    for (int c = 1; c <= DEPTH + CELLS + 6; c++) begin
      @(negedge clk);
      if (out_valid) begin
        if (first_lat < 0) first_lat = c;
        if (model_n == 0) chk(1'b0, req, int'(out_data), -1);
        else begin
          int e = model_take();
          chk(int'(out_data) == e, req, int'(out_data), e);
        end
        got++;
        if (k >= 0 && got == k) begin mode_pop = 1'b0; break; end
      end
    end
    mode_pop = 1'b0;
    if (k < 0) begin
      chk(got == exp_n, "R5 count", got, exp_n);
      chk(empty == 1'b1, "R5 empty", int'(empty), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(empty == 1'b1, "R1 empty", int'(empty), 1);
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    rst_n = 1'b1;

    // R4 R5 R6: sweep of fill levels and value patterns
    for (int pat = 0; pat < 5; pat++) begin
      for (int n = 0; n <= DEPTH; n++) begin
        for (int i = 0; i < n; i++) begin
          case (pat)
            0: push(i * 3);
            1: push(250 - i * 7);
            2: push(42);
            3: push(i % 2 == 0 ? 9 : 200);
            default: push(next_rand());
          endcase
        end
        idle(0);
        chk(full == (n == DEPTH), "R3 full flag", int'(full), int'(n == DEPTH));
        drain(-1, pat == 2 ? "R6 duplicates" : "R4 ascending");
      end
    end

    // R3: extra loads while full are dropped
    for (int i = 0; i < DEPTH; i++) push(100 - i);
    idle(0);
    chk(full == 1'b1, "R3 full set", int'(full), 1);
    push(1); push(2);
    model_n = DEPTH;
    idle(0);
    drain(-1, "R3 overflow dropped");

    // R2: in_valid low and drain-mode data are ignored
    push(50); idle(3); idle(4); push(60); idle(5);
    drain(-1, "R2 gaps ignored");
    @(negedge clk);
    mode_pop = 1'b1; in_valid = 1'b1; in_data = 8'd7;
    repeat (3) @(negedge clk);
    mode_pop = 1'b0; in_valid = 1'b0;
    chk(empty == 1'b1 && out_valid == 1'b0, "R2 drain-mode load ignored", int'(empty), 1);

    // R7: rising keys all descend; the first output is bounded
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < DEPTH; i++) push(r + i * 10);
      drain(-1, "R7 order");
      chk(first_lat >= 1 && first_lat <= CELLS, "R7 first latency", first_lat, CELLS);
    end

    // R8: partial drain, reload, merged drain
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < 6; i++) push(next_rand());
      drain(3, "R8 partial");
      chk(empty == 1'b0, "R8 not empty", int'(empty), 0);
      for (int i = 0; i < 4; i++) push(next_rand());
      idle(0);
      drain(-1, "R8 merged");
    end

    finish_run();
  end

endmodule